// File: doc/BRIEF.md
# Dual-Tone FSK Sine Synthesizer

This block generates the two audio tones of a 1200/2200 Hz frequency-shift-keyed modem by direct digital synthesis, and presents four tone streams at once as pulse-width-modulated outputs. Three 32-bit phase accumulators advance on every sample tick. The first runs at a fixed 1200 Hz. The second runs at a fixed 2200 Hz. The third takes its increment from the mark/space select input. Each accumulator's top 8 bits address a sine lookup, and the results become 8-bit PWM duty codes.

There are four streams. Two are the fixed tones. The third is a continuous-phase FSK signal from the switched accumulator, whose phase carries over a tone change. The fourth is a coherent-phase FSK signal that simply picks the sine of one of the two free-running accumulators. A free-running 8-bit PWM counter sets the period. All four duty codes are latched together when it wraps, and each output is high while the counter is below its duty. The sample tick is expected at 62.5 kHz, so the increments equal f·2^32/62500.

Top module: `fsk_tone_gen`

## Requirements
- R1: While reset is held and after it is released, and before any sample tick, all four duty outputs read 128, the sine code at phase zero.
- R2: On each cycle with `sampleTick` high, the 1200 Hz accumulator adds 82,463,372 modulo 2^32. At the next PWM wrap, `dutyLow` becomes the sine code of that accumulator's top 8 bits. Without a tick, the duty does not change.
- R3: On each tick, the 2200 Hz accumulator adds 151,182,849 modulo 2^32. `dutyHigh` shows its sine code after the next wrap.
- R4: On each tick, the continuous-phase accumulator adds the 2200 Hz increment when `selHigh` is 1 and the 1200 Hz increment when it is 0. Its value is kept across a select change, and `dutyCont` shows its sine code.
- R5: `dutyCoh` equals the sine code of the 2200 Hz accumulator when the select value sampled at the last tick was 1, and of the 1200 Hz accumulator when it was 0.
- R6: The sine code for table index k is round(127.5 + 126.5·sin(2πk/256)), so every duty code lies between 1 and 254 and none is 0.
- R7: The PWM counter counts 0 to 255 and wraps. Over any 256 consecutive clocks with a constant duty d, the corresponding `pwmOut` bit is high for exactly d clocks. Bit order: 0 low tone, 1 high tone, 2 continuous, 3 coherent.
- R8: All four duty codes change only on the clock at which the PWM counter wraps, and they change together.
- R9: A change of `selHigh` without a sample tick leaves `dutyCont` and `dutyCoh` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | One-cycle pulse that advances all accumulators |
| selHigh | input | 1 | Tone select: 1 = 2200 Hz, 0 = 1200 Hz, sampled on tick |
| dutyLow | output | 8 | Latched duty of the 1200 Hz stream |
| dutyHigh | output | 8 | Latched duty of the 2200 Hz stream |
| dutyCont | output | 8 | Latched duty of the continuous-phase FSK stream |
| dutyCoh | output | 8 | Latched duty of the coherent-phase FSK stream |
| pwmOut | output | 4 | PWM outputs, one bit per stream |

## Verification
The hardest case to reach is a phase that carries over a tone switch. The switched accumulator must keep the exact value it had reached, which is visible only after several ticks at each tone. So the bench toggles the select in the middle of a long tick run and follows the result with a 32-bit reference model of all three accumulators. The near-zero sine code at index 192 is reached within such runs. A select change with no tick is placed between wraps to show that it has no effect until a tick arrives.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  parameter int ACC_W  = 32;
  parameter int DUTY_W = 8;
  parameter logic [ACC_W-1:0] INC_LO = 32'd82463372;   // 1200 Hz at 62.5 kHz
  parameter logic [ACC_W-1:0] INC_HI = 32'd151182849;  // 2200 Hz at 62.5 kHz
  localparam int TBL_N = 2 ** DUTY_W;

  typedef struct packed {
    logic advance;    // step accumulators, sample select
    logic latchDuty;  // PWM period boundary
  } fsk_strobe_t;

  // Offset sine code; the smallest value is 1, never 0.
  function automatic int sineCode(input int k);
    real mid, amp, ang;
    mid = ((2.0 ** DUTY_W) - 1.0) / 2.0;
    amp = mid - 1.0;
    ang = 2.0 * 3.14159265358979 * k / TBL_N;
    return $rtoi(mid + amp * $sin(ang) + 0.5);
  endfunction
endpackage

// File: rtl/fsk_ctrl.sv
module fsk_ctrl
  import fsk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  output fsk_strobe_t       strb,
  output logic [DUTY_W-1:0] pwmCnt
);
  always_ff @(posedge clk) begin
    if (!rstN) pwmCnt <= '0;
    else       pwmCnt <= pwmCnt + 1'b1;
  end

  always_comb begin
    strb.advance   = sampleTick;
    strb.latchDuty = &pwmCnt;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchDuty |=> (pwmCnt == '0)); // R7
endmodule

// File: rtl/fsk_datapath.sv
module fsk_datapath
  import fsk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fsk_strobe_t       strb,
  input  logic [DUTY_W-1:0] pwmCnt,
  input  logic              selHigh,
  output logic [DUTY_W-1:0] dutyLow,
  output logic [DUTY_W-1:0] dutyHigh,
  output logic [DUTY_W-1:0] dutyCont,
  output logic [DUTY_W-1:0] dutyCoh,
  output logic [3:0]        pwmOut
);
  localparam int IDX_LSB = ACC_W - DUTY_W;
  localparam logic [DUTY_W-1:0] RST_DUTY = DUTY_W'(sineCode(0));

  logic [ACC_W-1:0]  accLow, accHigh, accCont;
  logic              selQ;
  logic [DUTY_W-1:0] sineRom [TBL_N];
  logic [DUTY_W-1:0] lkLow, lkHigh, lkCont;
  logic [DUTY_W-1:0] dutyArr [4];

  for (genvar k = 0; k < TBL_N; k++) begin : g_rom
    assign sineRom[k] = DUTY_W'(sineCode(k));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accLow  <= '0;
      accHigh <= '0;
      accCont <= '0;
      selQ    <= 1'b0;
    end else if (strb.advance) begin
      accLow  <= accLow + INC_LO;
      accHigh <= accHigh + INC_HI;
      accCont <= accCont + (selHigh ? INC_HI : INC_LO);
      selQ    <= selHigh;
    end
  end

  assign lkLow  = sineRom[accLow[ACC_W-1:IDX_LSB]];
  assign lkHigh = sineRom[accHigh[ACC_W-1:IDX_LSB]];
  assign lkCont = sineRom[accCont[ACC_W-1:IDX_LSB]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyLow  <= RST_DUTY;
      dutyHigh <= RST_DUTY;
      dutyCont <= RST_DUTY;
      dutyCoh  <= RST_DUTY;
    end else if (strb.latchDuty) begin
      dutyLow  <= lkLow;
      dutyHigh <= lkHigh;
      dutyCont <= lkCont;
      dutyCoh  <= selQ ? lkHigh : lkLow;
    end
  end

  assign dutyArr[0] = dutyLow;
  assign dutyArr[1] = dutyHigh;
  assign dutyArr[2] = dutyCont;
  assign dutyArr[3] = dutyCoh;

  for (genvar c = 0; c < 4; c++) begin : g_pwm
    assign pwmOut[c] = (pwmCnt < dutyArr[c]);
  end

  AST_DUTY_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dutyLow != '0) && (dutyHigh != '0) && (dutyCont != '0) && (dutyCoh != '0)); // R6
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchDuty |=> ($stable(dutyLow) && $stable(dutyHigh) && $stable(dutyCont) && $stable(dutyCoh))); // R8
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> ($stable(accLow) && $stable(accCont))); // R2
  AST_CONT_TRACKS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && selHigh) |=> ((accCont - $past(accCont)) == (accHigh - $past(accHigh)))); // R4
  AST_COH_PICK: assert property (@(posedge clk) disable iff (!rstN)
    (dutyCoh == dutyLow) || (dutyCoh == dutyHigh)); // R5
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              selHigh,
  output logic [DUTY_W-1:0] dutyLow,
  output logic [DUTY_W-1:0] dutyHigh,
  output logic [DUTY_W-1:0] dutyCont,
  output logic [DUTY_W-1:0] dutyCoh,
  output logic [3:0]        pwmOut
);
  fsk_strobe_t       strb;
  logic [DUTY_W-1:0] pwmCnt;

  fsk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .strb(strb), .pwmCnt(pwmCnt)
  );

  fsk_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pwmCnt(pwmCnt), .selHigh(selHigh),
    .dutyLow(dutyLow), .dutyHigh(dutyHigh), .dutyCont(dutyCont),
    .dutyCoh(dutyCoh), .pwmOut(pwmOut)
  );
endmodule

// File: tb/sim_fsk_tone_gen.sv
module sim_fsk_tone_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleTick = 1'b0;
  logic selHigh = 1'b0;
  logic [7:0] dutyLow, dutyHigh, dutyCont, dutyCoh;
  logic [3:0] pwmOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] mLo = 0, mHi = 0, mCont = 0;
  logic mSel = 1'b0;
  localparam logic [31:0] ILO = 32'd82463372;
  localparam logic [31:0] IHI = 32'd151182849;

  always #4 clk = ~clk;

  fsk_tone_gen u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .selHigh(selHigh),
    .dutyLow(dutyLow), .dutyHigh(dutyHigh), .dutyCont(dutyCont),
    .dutyCoh(dutyCoh), .pwmOut(pwmOut)
  );

  function automatic int sineRef(input logic [31:0] ph);
    real a;
    a = 2.0 * 3.14159265358979 * ph[31:24] / 256.0;
    return $rtoi(127.5 + 126.5 * $sin(a) + 0.5);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    sampleTick = 1'b1;
    mLo = mLo + ILO;
    mHi = mHi + IHI;
    mCont = mCont + (selHigh ? IHI : ILO);
    mSel = selHigh;
    @(negedge clk);
    sampleTick = 1'b0;
  endtask

  task automatic settle();
    repeat (300) @(negedge clk);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(dutyLow == 128 && dutyHigh == 128 && dutyCont == 128 && dutyCoh == 128,
          "R1 in reset", dutyLow, 128);
    rstN = 1'b1;
    settle();
    check(dutyLow == 128 && dutyCont == 128, "R1 after reset", dutyCont, 128);
    check(dutyCoh == 128 && dutyHigh == 128, "R1 after reset coh", dutyCoh, 128);
  endtask

  task automatic test_fixed_tones();
    bit okLo = 1, okHi = 1, okRng = 1;
    int badLo = 0, badHi = 0;
    for (int n = 0; n < 60; n++) begin
      tick();
      settle();
      if (dutyLow != sineRef(mLo)) begin okLo = 0; badLo = dutyLow; end
      if (dutyHigh != sineRef(mHi)) begin okHi = 0; badHi = dutyHigh; end
      if (dutyLow < 1 || dutyLow > 254 || dutyHigh < 1 || dutyHigh > 254) okRng = 0;
    end
    check(okLo, "R2 low tone samples", badLo, sineRef(mLo));
    check(okHi, "R3 high tone wraps", badHi, sineRef(mHi));
    check(okRng, "R6 duty range", dutyLow, 1);
    check(sineRef(32'hC000_0000) == 1 && sineRef(32'h4000_0000) == 254,
          "R6 reference extremes", sineRef(32'hC000_0000), 1);
  endtask

  task automatic test_fsk();
    bit okC = 1, okH = 1;
    int badC = 0, badH = 0, expH = 0;
    for (int n = 0; n < 80; n++) begin
      selHigh = ((n / 7) % 2) == 1;
      tick();
      settle();
      if (dutyCont != sineRef(mCont)) begin okC = 0; badC = dutyCont; end
      expH = mSel ? sineRef(mHi) : sineRef(mLo);
      if (dutyCoh != expH) begin okH = 0; badH = dutyCoh; end
    end
    check(okC, "R4 continuous phase", badC, sineRef(mCont));
    check(okH, "R5 coherent phase", badH, expH);
  endtask

  task automatic test_sel_no_tick();
    logic [7:0] c0, h0;
    c0 = dutyCont;
    h0 = dutyCoh;
    selHigh = ~mSel;
    settle();
    check(dutyCont == c0, "R9 cont held", dutyCont, c0);
    check(dutyCoh == h0, "R9 coh held", dutyCoh, h0);
    tick();
    settle();
    check(dutyCont == sineRef(mCont), "R4 after late switch", dutyCont, sineRef(mCont));
  endtask

  task automatic test_pwm();
    int hi [4];
    int d [4];
    for (int c = 0; c < 4; c++) hi[c] = 0;
    d[0] = dutyLow; d[1] = dutyHigh; d[2] = dutyCont; d[3] = dutyCoh;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) if (pwmOut[c]) hi[c]++;
    end
    for (int c = 0; c < 4; c++) check(hi[c] == d[c], "R7 pwm high count", hi[c], d[c]);
  endtask

  task automatic test_simultaneous();
    logic [7:0] l0, h0, c0, k0;
    int waitN = 0;
    bit moved = 0;
    selHigh = 1'b1;
    tick();
    l0 = dutyLow; h0 = dutyHigh; c0 = dutyCont; k0 = dutyCoh;
    while (!moved && waitN < 300) begin
      @(negedge clk);
      waitN++;
      if (dutyLow != l0 || dutyHigh != h0 || dutyCont != c0 || dutyCoh != k0) moved = 1;
    end
    check(dutyLow == sineRef(mLo) && dutyHigh == sineRef(mHi) &&
          dutyCont == sineRef(mCont) && dutyCoh == sineRef(mHi),
          "R8 joint update", dutyHigh, sineRef(mHi));
  endtask

  initial begin
    test_reset();
    test_fixed_tones();
    test_fsk();
    test_sel_no_tick();
    test_pwm();
    test_simultaneous();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule